// File: doc/BRIEF.md
# Point-to-Point Buffered Channel with Element Counting

This block carries data words from a single writer to a single reader. It offers two paths that share one write port. The buffered path passes through a small FIFO with flow control on both sides. The writer sees back-pressure through `wr_ready_o`. The reader pulls words by raising `rd_en_i` while `rd_ready_o` is high. The low-latency path is a register that always holds the word the writer presented most recently. It is updated whether or not the FIFO accepted that word.

On the read side, an element counter can be loaded with a requested total. It emits a one-cycle `done_o` strobe in the same cycle that the final requested word is delivered. Loading a negative total puts the channel into streaming mode, in which no strobe is ever produced. The data width, the FIFO depth and the counter width are parameters. A depth of zero removes the FIFO entirely and leaves only the register path.

Top module: `p2p_chan`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it, `rd_ready_o`, `rd_valid_o` and `done_o` are low, `xchg_data_o` is zero and `wr_ready_o` is high. Reset also discards every stored word.
- R2: `rd_ready_o` is high exactly when the FIFO storage holds at least one word. A word that has been accepted but is still in the input stage does not count.
- R3: When `rd_en_i` and `rd_ready_o` are both high in a cycle, the oldest stored word is removed. It appears on `rd_data_o`, with `rd_valid_o` high, in the next cycle. `rd_valid_o` is high only in such cycles, and words leave in the order they were accepted.
- R4: A word accepted in cycle t, with the FIFO otherwise empty and `rd_en_i` held high, appears with `rd_valid_o` in cycle t+3.
- R5: When `wr_valid_i` is high in cycle t, `xchg_data_o` equals that cycle's `wr_data_i` in cycle t+1. This holds even when the FIFO refuses the word.
- R6: A read request while `rd_ready_o` is low is ignored. `rd_valid_o` stays low in the next cycle and the request does not advance the element count.
- R7: `wr_ready_o` is low exactly when stored words plus words in the input stage equal DEPTH. A word offered while `wr_ready_o` is low is dropped and never delivered.
- R8: Pulsing `cnt_load_i` with a `cnt_total_i` of N ≥ 1 clears the received count. `done_o` is then high for one cycle, the same cycle in which the Nth word after the load is on `rd_data_o`. A total of 0 raises `done_o` in the cycle after the load. A load wins over a read in the same cycle: that word is not counted.
- R9: A load with a negative total (-1 selects streaming) produces no `done_o` until the next load. After the strobe of R8, no further strobe occurs until the next load.
- R10: With DEPTH = 0, `wr_ready_o` is always high, while `rd_ready_o` and `rd_valid_o` stay low. `xchg_data_o` still behaves as in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Writer presents a word |
| wr_data_i | input | DW | Writer data |
| wr_ready_o | output | 1 | FIFO can accept a word this cycle |
| rd_en_i | input | 1 | Reader requests one word |
| rd_ready_o | output | 1 | FIFO holds at least one word |
| rd_valid_o | output | 1 | `rd_data_o` carries a freshly read word |
| rd_data_o | output | DW | Buffered data to the reader |
| xchg_data_o | output | DW | Most recent writer word, unbuffered |
| cnt_load_i | input | 1 | Load a new element total |
| cnt_total_i | input | CNT_W | Signed element total; negative means streaming |
| done_o | output | 1 | One-cycle strobe when the total is reached |

## Verification
The assertions assume that `cnt_total_i` is stable in any cycle where `cnt_load_i` is high. They also assume that the reader tolerates a word arriving in any cycle after a request. The input-stage and occupancy properties assume nothing about writer behaviour beyond synchronous timing, because a refused word is simply dropped. The stimulus changes every input only on the falling clock edge. It loads totals from a small set that includes 0, small positives and -1, so every counting mode is reached many times under random read and write pressure. It also places loads in the same cycle as reads, so the load-priority rule is exercised.

// File: rtl/p2p_chan_pkg.sv
`timescale 1ns/1ps
package p2p_chan_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_COUNT  = 2'd1,
    MODE_STREAM = 2'd2
  } cnt_mode_e;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/p2p_xchg_reg.sv
`timescale 1ns/1ps
module p2p_xchg_reg #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] xchg_data_o
);
  logic [DW-1:0] xchg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         xchg_q <= '0;
    else if (wr_valid_i) xchg_q <= wr_data_i;
  end

  assign xchg_data_o = xchg_q;

  assert_xchg_follows_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |=> (xchg_data_o == $past(wr_data_i)));
endmodule

// File: rtl/p2p_fifo.sv
`timescale 1ns/1ps
module p2p_fifo #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_valid_i,
  input  logic [DW-1:0] wr_data_i,
  output logic          wr_ready_o,
  input  logic          rd_en_i,
  output logic          rd_ready_o,
  output logic          rd_valid_o,
  output logic [DW-1:0] rd_data_o,
  output logic          pop_o
);
  localparam int unsigned AW = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int unsigned CW = p2p_chan_pkg::cnt_bits(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [CW-1:0] count_q;
  logic          stage_v_q;
  logic [DW-1:0] stage_d_q;
  logic          rd_valid_q;
  logic [DW-1:0] rd_data_q;
  logic [CW:0]   occ;
  logic          accept, push, pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // occupancy counts the input stage so an accepted word always has a slot
  assign occ        = {1'b0, count_q} + (CW+1)'(stage_v_q);
  assign wr_ready_o = (occ < (CW+1)'(DEPTH));
  assign accept     = wr_valid_i && wr_ready_o;
  assign push       = stage_v_q;
  assign rd_ready_o = (count_q != '0);
  assign pop        = rd_en_i && rd_ready_o;
  assign pop_o      = pop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_v_q <= 1'b0;
      stage_d_q <= '0;
    end else begin
      stage_v_q <= accept;
      if (accept) stage_d_q <= wr_data_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem[wptr_q] <= stage_d_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) wptr_q <= ptr_inc(wptr_q);
      if (pop)  rptr_q <= ptr_inc(rptr_q);
      case ({push, pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= pop;
      if (pop) rd_data_q <= mem[rptr_q];
    end
  end

  assign rd_valid_o = rd_valid_q;
  assign rd_data_o  = rd_data_q;

  assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |-> (count_q < CW'(DEPTH)));
  assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && (count_q == '0) |=> !rd_valid_o);
  assert_valid_after_pop_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop |=> rd_valid_o);
  assert_ready_from_stage_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_ready_o) |-> $past(stage_v_q));
  assert_full_refuses_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_ready_o |=> !stage_v_q);
endmodule

// File: rtl/p2p_elem_counter.sv
`timescale 1ns/1ps
module p2p_elem_counter
  import p2p_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic signed [CNT_W-1:0] total_i,
  input  logic                    pop_i,
  output logic                    done_o
);
  cnt_mode_e        mode_q;
  logic [CNT_W-1:0] rx_q, tot_q, rx_nxt;
  logic             done_q;

  assign rx_nxt = rx_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
      rx_q   <= '0;
      tot_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_i) begin
        // load wins over a same-cycle read
        rx_q  <= '0;
        tot_q <= $unsigned(total_i);
        if (total_i < 0) begin
          mode_q <= MODE_STREAM;
        end else if (total_i == '0) begin
          mode_q <= MODE_IDLE;
          done_q <= 1'b1;
        end else begin
          mode_q <= MODE_COUNT;
        end
      end else if (pop_i && mode_q == MODE_COUNT) begin
        rx_q <= rx_nxt;
        if (rx_nxt == tot_q) begin
          done_q <= 1'b1;
          mode_q <= MODE_IDLE;
        end
      end
    end
  end

  assign done_o = done_q;

  assert_done_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !load_i |=> !done_o);
  assert_stream_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_COUNT) && !load_i |=> !done_o);
  assert_done_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(load_i) || $past(pop_i));
endmodule

// File: rtl/p2p_chan.sv
`timescale 1ns/1ps
module p2p_chan #(
  parameter int unsigned DW    = 16,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_valid_i,
  input  logic [DW-1:0]           wr_data_i,
  output logic                    wr_ready_o,
  input  logic                    rd_en_i,
  output logic                    rd_ready_o,
  output logic                    rd_valid_o,
  output logic [DW-1:0]           rd_data_o,
  output logic [DW-1:0]           xchg_data_o,
  input  logic                    cnt_load_i,
  input  logic signed [CNT_W-1:0] cnt_total_i,
  output logic                    done_o
);
  logic pop;

  p2p_xchg_reg #(.DW(DW)) i_xchg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_valid_i  (wr_valid_i),
    .wr_data_i   (wr_data_i),
    .xchg_data_o (xchg_data_o)
  );

  if (DEPTH == 0) begin : g_nobuf
    assign wr_ready_o = 1'b1;
    assign rd_ready_o = 1'b0;
    assign rd_valid_o = 1'b0;
    assign rd_data_o  = '0;
    assign pop        = 1'b0;
  end else begin : g_buf
    if (DEPTH < 4) begin : g_bad_depth
      $error("p2p_chan: DEPTH must be 0 or at least 4");
    end
    p2p_fifo #(.DW(DW), .DEPTH(DEPTH)) i_fifo (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .wr_valid_i (wr_valid_i),
      .wr_data_i  (wr_data_i),
      .wr_ready_o (wr_ready_o),
      .rd_en_i    (rd_en_i),
      .rd_ready_o (rd_ready_o),
      .rd_valid_o (rd_valid_o),
      .rd_data_o  (rd_data_o),
      .pop_o      (pop)
    );
  end

  p2p_elem_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (cnt_load_i),
    .total_i (cnt_total_i),
    .pop_i   (pop),
    .done_o  (done_o)
  );

  assert_done_with_data_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !$past(cnt_load_i) |-> rd_valid_o);
endmodule

// File: tb/test_p2p_chan.sv
`timescale 1ns/1ps
module test_p2p_chan;
  localparam int DW = 16, DEPTH = 4, CNT_W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, rd_en = 1'b0, load = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic signed [CNT_W-1:0] total = '0;
  logic wr_ready, rd_ready, rd_valid, done;
  logic [DW-1:0] rd_data, xchg;
  logic z_wr_ready, z_rd_ready, z_rd_valid, z_done;
  logic [DW-1:0] z_rd_data, z_xchg;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  bit model_on = 0;

  always #2.5 clk = ~clk;

  p2p_chan #(.DW(DW), .DEPTH(DEPTH), .CNT_W(CNT_W)) i_p2p_chan (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_ready_o(wr_ready), .rd_en_i(rd_en), .rd_ready_o(rd_ready),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .xchg_data_o(xchg),
    .cnt_load_i(load), .cnt_total_i(total), .done_o(done));

  p2p_chan #(.DW(DW), .DEPTH(0), .CNT_W(CNT_W)) i_p2p_chan_nobuf (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_data_i(wr_data),
    .wr_ready_o(z_wr_ready), .rd_en_i(rd_en), .rd_ready_o(z_rd_ready),
    .rd_valid_o(z_rd_valid), .rd_data_o(z_rd_data), .xchg_data_o(z_xchg),
    .cnt_load_i(load), .cnt_total_i(total), .done_o(z_done));

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [DW-1:0] q[$];
  bit            m_stage_v;
  logic [DW-1:0] m_stage_d, m_rd_data, m_xchg;
  bit            m_valid, m_done, m_armed;
  int            m_rx, m_tot;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_stage_v = 0; m_stage_d = '0; m_rd_data = '0; m_xchg = '0;
      m_valid = 0; m_done = 0; m_armed = 0; m_rx = 0; m_tot = 0;
    end else begin
      bit pop, acc;
      pop = rd_en && (q.size() > 0);
      acc = wr_valid && ((q.size() + int'(m_stage_v)) < DEPTH);
      m_valid = pop;
      if (pop) m_rd_data = q.pop_front();
      if (m_stage_v) q.push_back(m_stage_d);
      m_stage_v = acc;
      if (acc) m_stage_d = wr_data;
      if (wr_valid) m_xchg = wr_data;
      m_done = 0;
      if (load) begin
        m_rx = 0; m_tot = int'(total);
        if (m_tot == 0) begin m_done = 1; m_armed = 0; end
        else m_armed = (m_tot > 0);
      end else if (pop && m_armed) begin
        m_rx++;
        if (m_rx == m_tot) begin m_done = 1; m_armed = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n && !finished) begin
      chk(rd_ready == (q.size() > 0), "R2 rd_ready", rd_ready, q.size() > 0);
      chk(rd_valid == m_valid, "R3/R6 rd_valid", rd_valid, m_valid);
      if (m_valid) chk(rd_data == m_rd_data, "R3 rd_data", rd_data, m_rd_data);
      chk(xchg == m_xchg, "R5 xchg", xchg, m_xchg);
      chk(wr_ready == ((q.size() + int'(m_stage_v)) < DEPTH), "R7 wr_ready",
          wr_ready, (q.size() + int'(m_stage_v)) < DEPTH);
      chk(done == m_done, "R8/R9 done", done, m_done);
      chk(z_wr_ready && !z_rd_ready && !z_rd_valid, "R10 nobuf flags",
          {z_wr_ready, z_rd_ready, z_rd_valid}, 3'b100);
      chk(z_xchg == m_xchg, "R10 nobuf xchg", z_xchg, m_xchg);
    end
  end

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_reset_state();
    chk(!rd_ready && !rd_valid && !done, "R1 flags", {rd_ready, rd_valid, done}, 0);
    chk(xchg == '0, "R1 xchg", xchg, 0);
    chk(wr_ready, "R1 wr_ready", wr_ready, 1);
  endtask

  task automatic rand_phase(input int n, input int load_pct);
    for (int i = 0; i < n; i++) begin
      wr_valid = ($urandom_range(0, 99) < 60);
      wr_data  = DW'($urandom);
      rd_en    = ($urandom_range(0, 99) < 50);
      load     = ($urandom_range(0, 99) < load_pct);
      case ($urandom_range(0, 3))
        0: total = -1;
        1: total = 0;
        default: total = CNT_W'($urandom_range(1, 5));
      endcase
      cyc();
    end
    load = 0; wr_valid = 0; rd_en = 0;
  endtask

  initial begin
    int pulses;
    cyc(3);
    check_reset_state();                     // R1 during reset
    rst_n = 1'b1;
    cyc();
    check_reset_state();                     // R1 after release
    model_on = 1;

    // R4 / R5 latency
    rd_en = 1; wr_valid = 1; wr_data = 16'hA5C3;
    cyc();
    wr_valid = 0;
    chk(xchg == 16'hA5C3, "R5 one-cycle xchg", xchg, 16'hA5C3);
    chk(!rd_valid, "R4 not early t+1", rd_valid, 0);
    cyc();
    chk(!rd_valid && rd_ready, "R4 t+2 stored not read", {rd_valid, rd_ready}, 2'b01);
    cyc();
    chk(rd_valid && rd_data == 16'hA5C3, "R4 valid at t+3", {rd_valid, rd_data}, {1'b1, 16'hA5C3});
    rd_en = 0;
    cyc(2);

    // R7 fill past capacity, R5 refused word still seen
    for (int i = 0; i < 7; i++) begin
      wr_valid = 1; wr_data = DW'(16'h100 + i);
      cyc();
    end
    wr_valid = 0;
    chk(!wr_ready, "R7 full", wr_ready, 0);
    chk(xchg == 16'h106, "R5 refused word in xchg", xchg, 16'h106);

    // drain and read past empty (R6)
    rd_en = 1;
    cyc(10);
    chk(!rd_valid && !rd_ready, "R6 empty read ignored", {rd_valid, rd_ready}, 0);
    rd_en = 0;

    // R8 counted transfer of 3
    load = 1; total = 3; cyc(); load = 0;
    pulses = 0;
    for (int i = 0; i < 30; i++) begin
      wr_valid = (i < 6); wr_data = DW'(16'h200 + i); rd_en = 1;
      cyc();
      if (done) pulses++;
    end
    rd_en = 0; wr_valid = 0;
    chk(pulses == 1, "R8 exactly one done", pulses, 1);

    // R8 total 0
    load = 1; total = 0; cyc(); load = 0;
    chk(done, "R8 zero total done", done, 1);
    cyc();

    // R9 streaming
    load = 1; total = -1; cyc(); load = 0;
    pulses = 0;
    for (int i = 0; i < 30; i++) begin
      wr_valid = 1; wr_data = DW'($urandom); rd_en = 1;
      cyc();
      if (done) pulses++;
    end
    rd_en = 0; wr_valid = 0;
    chk(pulses == 0, "R9 stream no done", pulses, 0);

    // R8 load concurrent with read (load wins)
    wr_valid = 1; wr_data = 16'h0301; cyc(); wr_valid = 0; cyc(2);
    load = 1; total = 1; rd_en = 1; cyc(); load = 0; rd_en = 0;
    chk(rd_valid && !done, "R8 load beats read", {rd_valid, done}, 2'b10);
    cyc();

    rand_phase(600, 8);
    rand_phase(300, 2);

    // R1 reset mid-traffic
    wr_valid = 1; rd_en = 1;
    cyc(3);
    rst_n = 0; wr_valid = 0; rd_en = 0;
    cyc();
    check_reset_state();
    rst_n = 1;
    cyc();
    check_reset_state();
    rand_phase(100, 5);
    cyc(3);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule